// File: doc/BRIEF.md
# Multi-Mode Tuning Frequency Divider

This block is the divide-by-N stage of a tuning synthesizer. It divides a local-oscillator pulse stream down for a phase comparator. Two inputs arrive as single-cycle strobes in the system clock domain, one strobe per oscillator cycle: a high-band input and a low-band input. A band bit picks which input is counted, and on the low band a mode bit picks one of two dividers. The first is a 16-bit counter fed directly by the input. The second is a separate 12-bit divider that allows smaller divisors. The high band always passes through a divide-by-two prescaler before the 16-bit counter, so its overall ratio is twice the programmed value.

The divisor, band and mode bits are captured when `cfg_load` is asserted. They take effect at the next period boundary of the running divider. A period boundary is the point where the divider has just completed a period and has not yet counted an input of the next one. For this reason a period in progress is never shortened or stretched by a new setting. A programmed value of zero stands for the top of the range. A value below the path's minimum is raised to that minimum and is flagged. The strobe inputs carry no handshake. The block accepts one strobe per clock on each input and never applies back-pressure, so the source must not expect a strobe to be held or replayed.

Top module: `tune_divider`

## Requirements
- R1: When `cfg_band` is 1 the divider counts `hi_pulse` strobes. When it is 0 it counts `lo_pulse` strobes. Strobes on the unselected input have no effect on the output period.
- R2: With band 1, one output pulse is produced per 2*N selected strobes, where N is the effective 16-bit divisor. `cfg_mode` has no effect with band 1.
- R3: With band 0 and mode 1, one output pulse is produced per N strobes, where N is taken from all 16 bits of `cfg_div`.
- R4: With band 0 and mode 0, one output pulse is produced per N strobes, where N is taken from `cfg_div[11:0]`. Bits 15..12 are ignored on this path.
- R5: A zero field encodes the top of its range: 65536 on the 16-bit paths and 4096 on the 12-bit path.
- R6: A nonzero field below the path minimum is replaced by that minimum. The minimum is 256 on the 16-bit paths and 4 on the 12-bit path. In that case `range_err` reads 1 while the period that uses the setting runs. For an in-range setting it reads 0.
- R7: Settings captured by `cfg_load` in the middle of a period do not change the length of that period. They apply from the next period on.
- R8: `div_pulse` is high for exactly one clock. That clock is the one right after the clock edge that takes in the strobe completing a period.
- R9: A synchronous reset clears the counters, the prescaler phase and the staged settings. The staged settings return to band 0, mode 0, field 0. After reset both outputs read 0, and the first pulse comes only after a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_pulse | input | 1 | High-band oscillator strobe, one per input cycle |
| lo_pulse | input | 1 | Low-band oscillator strobe, one per input cycle |
| cfg_load | input | 1 | Captures cfg_div, cfg_band and cfg_mode |
| cfg_div | input | 16 | Programmed divisor field |
| cfg_band | input | 1 | 1 selects the high band, 0 the low band |
| cfg_mode | input | 1 | Low band only: 1 selects the 16-bit counter, 0 the 12-bit divider |
| div_pulse | output | 1 | Divided output pulse, one clock wide |
| range_err | output | 1 | Active setting was below the path minimum and was clamped |

## Verification
Several properties are checked on every cycle:
- The output pulse is a single clock wide and always follows a received strobe.
- Both outputs stay quiet right after reset.
- The prescaler phase is only ever set while the high band is active.
- The counter of the unused path stays at zero.

Only the bench's scenarios can show that the number of strobes between pulses matches N, 2N, the zero-encoded maxima and the clamped minima. The same holds for a setting loaded mid-period taking effect exactly one period later. Those scenarios also show that strobes on the unselected input leave the period untouched.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  typedef enum logic [1:0] {
    PATH_PRESCALE = 2'd0,
    PATH_WIDE     = 2'd1,
    PATH_NARROW   = 2'd2
  } path_e;

  function automatic path_e path_of(input logic band, input logic mode);
    if (band)      return PATH_PRESCALE;
    else if (mode) return PATH_WIDE;
    else           return PATH_NARROW;
  endfunction
endpackage

// File: rtl/tdiv_stage.sv
// Holds staged settings and the settings of the running period.
module tdiv_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] div_in,
  input  logic         band_in,
  input  logic         mode_in,
  input  logic         at_start,
  output logic [W-1:0] eff_div,
  output logic         eff_band,
  output logic         eff_mode,
  output logic [W-1:0] act_div,
  output logic         act_band,
  output logic         act_mode
);
  logic [W-1:0] st_div;
  logic         st_band, st_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_div  <= '0;
      st_band <= 1'b0;
      st_mode <= 1'b0;
    end else if (load) begin
      st_div  <= div_in;
      st_band <= band_in;
      st_mode <= mode_in;
    end
  end

  // staged values only become live while no period is in progress
  always_comb begin
    eff_div  = at_start ? st_div  : act_div;
    eff_band = at_start ? st_band : act_band;
    eff_mode = at_start ? st_mode : act_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div  <= '0;
      act_band <= 1'b0;
      act_mode <= 1'b0;
    end else begin
      act_div  <= eff_div;
      act_band <= eff_band;
      act_mode <= eff_mode;
    end
  end
endmodule

// File: rtl/tdiv_limit.sv
// Maps a divisor field to the terminal count value, with zero and clamp handling.
module tdiv_limit #(
  parameter int W   = 16,
  parameter int MIN = 256
) (
  input  logic [W-1:0] field,
  output logic [W-1:0] last,
  output logic         low
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  logic zero;

  always_comb begin
    zero = (field == '0);
    low  = !zero && (field < MIN_V);
    if (zero)     last = '1;
    else if (low) last = MIN_V - 1'b1;
    else          last = field - 1'b1;
  end
endmodule

// File: rtl/tdiv_count.sv
// Counts ticks from zero up to last, then wraps and flags terminal count.
module tdiv_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         tc,
  output logic [W-1:0] count
);
  assign tc = tick && (count == last);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= tc ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/tune_divider.sv
module tune_divider #(
  parameter int WIDE_W     = 16,
  parameter int NARROW_W   = 12,
  parameter int WIDE_MIN   = 256,
  parameter int NARROW_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_pulse,
  input  logic              lo_pulse,
  input  logic              cfg_load,
  input  logic [WIDE_W-1:0] cfg_div,
  input  logic              cfg_band,
  input  logic              cfg_mode,
  output logic              div_pulse,
  output logic              range_err
);
  import tdiv_pkg::*;

  logic [WIDE_W-1:0]   eff_div, act_div;
  logic                eff_band, eff_mode, act_band, act_mode;
  logic [WIDE_W-1:0]   last_wide, cnt_wide;
  logic [NARROW_W-1:0] last_narrow, cnt_narrow;
  logic                low_wide, low_narrow;
  logic                tc_wide, tc_narrow, tick_wide, tick_narrow;
  logic                ph, sel, at_start;
  path_e               path;

  assign at_start = !ph && (cnt_wide == '0) && (cnt_narrow == '0);

  tdiv_stage #(.W(WIDE_W)) u_stage (
    .clk(clk), .rst(rst), .load(cfg_load), .div_in(cfg_div),
    .band_in(cfg_band), .mode_in(cfg_mode), .at_start(at_start),
    .eff_div(eff_div), .eff_band(eff_band), .eff_mode(eff_mode),
    .act_div(act_div), .act_band(act_band), .act_mode(act_mode)
  );

  assign path = path_of(eff_band, eff_mode);
  assign sel  = eff_band ? hi_pulse : lo_pulse;

  // prescaler: every second selected strobe reaches the wide counter
  always_ff @(posedge clk) begin
    if (rst)                                ph <= 1'b0;
    else if (path == PATH_PRESCALE && sel)  ph <= ~ph;
  end

  always_comb begin
    tick_wide   = 1'b0;
    tick_narrow = 1'b0;
    case (path)
      PATH_PRESCALE: tick_wide   = sel && ph;
      PATH_WIDE:     tick_wide   = sel;
      default:       tick_narrow = sel;
    endcase
  end

  tdiv_limit #(.W(WIDE_W), .MIN(WIDE_MIN)) u_lim_wide (
    .field(eff_div), .last(last_wide), .low(low_wide)
  );
  tdiv_limit #(.W(NARROW_W), .MIN(NARROW_MIN)) u_lim_narrow (
    .field(eff_div[NARROW_W-1:0]), .last(last_narrow), .low(low_narrow)
  );

  tdiv_count #(.W(WIDE_W)) u_cnt_wide (
    .clk(clk), .rst(rst), .tick(tick_wide), .last(last_wide),
    .tc(tc_wide), .count(cnt_wide)
  );
  tdiv_count #(.W(NARROW_W)) u_cnt_narrow (
    .clk(clk), .rst(rst), .tick(tick_narrow), .last(last_narrow),
    .tc(tc_narrow), .count(cnt_narrow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse <= 1'b0;
      range_err <= 1'b0;
    end else begin
      div_pulse <= tc_wide || tc_narrow;
      range_err <= (path == PATH_NARROW) ? low_narrow : low_wide;
    end
  end
endmodule

// File: rtl/tune_divider_chk.sv
module tune_divider_chk #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                hi_pulse,
  input logic                lo_pulse,
  input logic                div_pulse,
  input logic                ph,
  input logic                act_band,
  input logic                act_mode,
  input logic [WIDE_W-1:0]   cnt_wide,
  input logic [NARROW_W-1:0] cnt_narrow
);
  // R8: the output pulse is one clock wide
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R8: a pulse is always caused by a strobe in the previous clock
  a_r8_pulse_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(hi_pulse || lo_pulse));

  // R9: outputs are quiet right after reset
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !div_pulse);

  // R2: the prescaler phase is only set while the high band runs
  a_r2_prescale_only_high: assert property (@(posedge clk) disable iff (rst)
    ph |-> act_band);

  // R4: the unused counter rests at zero
  a_r4_narrow_idle: assert property (@(posedge clk) disable iff (rst)
    (act_band || act_mode) |-> (cnt_narrow == '0));
  a_r3_wide_idle: assert property (@(posedge clk) disable iff (rst)
    (!act_band && !act_mode) |-> (cnt_wide == '0));
endmodule

bind tune_divider tune_divider_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .hi_pulse(hi_pulse), .lo_pulse(lo_pulse),
  .div_pulse(div_pulse), .ph(ph), .act_band(act_band), .act_mode(act_mode),
  .cnt_wide(cnt_wide), .cnt_narrow(cnt_narrow)
);

// File: tb/tune_divider_test.sv
module tune_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hi_pulse = 1'b0, lo_pulse = 1'b0, cfg_load = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        cfg_band = 1'b0, cfg_mode = 1'b0;
  logic        div_pulse, range_err;

  tune_divider uut (
    .clk(clk), .rst(rst), .hi_pulse(hi_pulse), .lo_pulse(lo_pulse),
    .cfg_load(cfg_load), .cfg_div(cfg_div), .cfg_band(cfg_band),
    .cfg_mode(cfg_mode), .div_pulse(div_pulse), .range_err(range_err)
  );

  always #4 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cycles = 0, pulses = 0;
  bit    timeout = 0, dense = 0, req = 0, mid = 0, post_rst = 0, after = 0;
  bit    m_band = 0, m_mode = 0, p_band = 0;
  logic [15:0] m_div = '0;
  int    cnt = 0, exp_len = 0;
  bit    exp_flag = 0;
  string tag = "";

  function automatic int eff_n(bit b, bit m, logic [15:0] d);
    logic [11:0] f;
    if (b || m) return (d == 0) ? 65536 : ((d < 256) ? 256 : int'(d));
    f = d[11:0];
    return (f == 0) ? 4096 : ((f < 4) ? 4 : int'(f));
  endfunction

  function automatic bit eff_low(bit b, bit m, logic [15:0] d);
    if (b || m) return (d != 0) && (d < 256);
    return (d[11:0] != 0) && (d[11:0] < 4);
  endfunction

  task automatic check(bit ok, string t, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic step();
    bit h, l, s;
    @(negedge clk);
    cycles++;
    if (after) check(div_pulse == 1'b0, "R8 pulse width", int'(div_pulse), 0);
    after = 0;
    if (div_pulse) begin
      check(cnt == exp_len, {tag, mid ? " R7" : "", post_rst ? " R9" : ""}, cnt, exp_len);
      check(range_err == exp_flag, "R6 range flag", int'(range_err), int'(exp_flag));
      pulses++; cnt = 0; after = 1; post_rst = 0;
    end
    h = dense || ($urandom_range(3) != 0);
    l = dense || ($urandom_range(3) != 0);
    if (cnt == 0) begin
      p_band   = m_band;
      exp_len  = (m_band ? 2 : 1) * eff_n(m_band, m_mode, m_div);
      exp_flag = eff_low(m_band, m_mode, m_div);
      mid      = 0;
      tag = m_band ? "R1 R2 high band" : (m_mode ? "R1 R3 wide" : "R4 narrow");
      if ((m_band || m_mode) ? (m_div == 0) : (m_div[11:0] == 0)) tag = {tag, " R5"};
    end
    hi_pulse = h;
    lo_pulse = l;
    s = p_band ? h : l;
    if (s) cnt++;
    cfg_load = req;
    if (req) begin
      m_band = cfg_band; m_mode = cfg_mode; m_div = cfg_div;
      if (cnt != 0) mid = 1;
    end
    req = 0;
  endtask

  task automatic load(bit b, bit m, logic [15:0] d);
    cfg_band = b; cfg_mode = m; cfg_div = d; req = 1;
    step();
  endtask

  task automatic run(int k);
    int target;
    target = pulses + k;
    while (pulses < target && !timeout) begin
      step();
      if (cycles > 190000) begin
        timeout = 1;
        check(0, "watchdog", cycles, 190000);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; hi_pulse = 0; lo_pulse = 0; cfg_load = 0; req = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_band = 0; m_mode = 0; m_div = '0; cnt = 0; after = 0; post_rst = 1;
    check(div_pulse == 0, "R9 pulse after reset", int'(div_pulse), 0);
    check(range_err == 0, "R9 flag after reset", int'(range_err), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0717));
    do_reset();
    // directed corners
    load(1, 0, 16'd300);   run(2);
    load(1, 1, 16'd300);   run(2);   // mode ignored on high band
    load(0, 1, 16'd700);   run(2);
    load(0, 0, 16'd9);     run(3);
    load(0, 0, 16'h2010);  run(2);   // upper bits ignored on narrow path
    load(0, 1, 16'd5);     run(2);   // clamp to 256
    load(0, 0, 16'd2);     run(2);   // clamp to 4
    load(1, 0, 16'd100);   run(2);   // clamp, ratio 512
    load(0, 0, 16'd0);     run(1);   // 4096
    dense = 1;
    load(0, 1, 16'd0);     run(1);   // 65536
    dense = 0;
    // mid-period change
    load(0, 0, 16'd40);    run(1);
    repeat (10) step();
    load(0, 0, 16'd7);     run(3);
    repeat (5) step();
    load(1, 0, 16'd260);   run(3);
    // reset during a period
    load(0, 0, 16'd100);
    repeat (30) step();
    do_reset();
    load(0, 0, 16'd10);    run(2);
    // constrained random
    for (int i = 0; i < 14 && !timeout; i++) begin
      bit b, m;
      logic [15:0] d;
      b = 1'($urandom_range(1));
      m = 1'($urandom_range(1));
      if (b || m) d = 16'($urandom_range(200, 600));
      else        d = 16'($urandom_range(0, 300)) | (16'($urandom_range(15)) << 12);
      if (!b && !m && d[11:0] == 0) d = d | 16'd1;
      load(b, m, d);
      run(1);
      repeat ($urandom_range(0, 8)) step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule